// File: doc/BRIEF.md
# Oversampled Serial Receiver with Tagged Receive Queue

This block turns an asynchronous serial line into characters. A one-cycle enable pulse arrives at sixteen times the bit rate. Each frame starts with a low start bit, which the receiver confirms half a bit later. The data bits are then sampled at the centre of each bit, least significant bit first. After the data come an optional parity bit and one or two stop bits. For every frame received, one 12-bit entry is written to a small queue. The entry holds the character and four status flags.

Static configuration inputs select the following:
- the character length, from five to eight bits
- the parity scheme: none, even, odd, or a fixed "stick" value
- the number of stop bits
- whether the queue uses its full depth or behaves as a single holding register

The consumer reads the queue through a show-ahead port. The read data is always the oldest entry, and a read strobe removes it. A level output is raised once the queue holds at least a chosen fraction of its depth.

A line held low for longer than a complete frame is reported as a break. Only one all-zero entry is stored for the whole break. A character that arrives while the queue is full is discarded. The next character that is stored carries an overrun mark.

Top module: `sio_rx_unit`

## Requirements
- R1: `cfg_wlen` selects 5, 6, 7 or 8 data bits (codes 0 to 3). The bits are received least significant first and appear in `rd_data[7:0]`, with unused upper bits set to zero.
- R2: When `cfg_par_en` is 1 and `cfg_par_stick` is 0, one parity bit follows the data. With `cfg_par_even`=1 the data plus parity must hold an even number of ones, and with `cfg_par_even`=0 an odd number. A mismatch sets bit 9 of the entry.
- R3: In stick mode (`cfg_par_en`=1, `cfg_par_stick`=1), the expected parity bit is the inverse of `cfg_par_even`. A received bit that differs from it sets bit 9.
- R4: When `cfg_par_en` is 0, no parity bit is taken from the line and bit 9 is always 0.
- R5: A low first stop bit sets bit 8 (framing error). When `cfg_two_stop` is 1, a low second stop bit also sets bit 8. A frame whose stop bits are all high leaves bit 8 clear.
- R6: A low pulse on `rxd` that is over before the eighth sample tick after it was detected is treated as a false start. No entry is written.
- R7: If every sampled bit of a frame, including the first stop bit, is low, one entry is written with bit 10 set (break), data zero and bits 9 and 8 clear. Nothing more is written until the line returns high.
- R8: A character completed while the queue is full is dropped. The next character that is stored has bit 11 (overrun) set.
- R9: The queue holds 16 entries when `cfg_fifo_en` is 1 and one entry when it is 0. `rx_full` is 1 exactly when that depth is reached.
- R10: With the queue enabled, `rx_irq` is 1 while the fill level is at least 2, 4, 8, 12 or 14 entries, for `cfg_lvl` codes 0, 1, 2, 3 and 4 or above respectively. With the queue disabled, `rx_irq` is 1 whenever an entry is held.
- R11: `rd_data` shows the oldest entry. A high `rd_en` on a clock edge removes that entry. `rd_en` while the queue is empty has no effect on later entries.
- R12: After reset the queue is empty: `rx_empty` is 1, and `rx_full` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick16 | input | 1 | One-cycle enable at sixteen times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_wlen | input | 2 | Data bit count minus five |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity select; in stick mode the inverse of the expected bit |
| cfg_par_stick | input | 1 | Stick parity select |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_fifo_en | input | 1 | Full-depth queue when 1, single entry when 0 |
| cfg_lvl | input | 3 | Fill threshold code for `rx_irq` |
| rd_en | input | 1 | Remove the oldest entry |
| rd_data | output | 12 | Oldest entry: [11] overrun, [10] break, [9] parity error, [8] framing error, [7:0] data |
| rx_empty | output | 1 | Queue holds no entry |
| rx_full | output | 1 | Queue at its selected depth |
| rx_irq | output | 1 | Fill threshold reached |

## Verification
The checker assumes that the configuration inputs change only while the queue is empty and the line is idle, because the single-entry bound and the threshold relation depend on them. It also assumes that `tick16` is a single-cycle pulse spaced several clocks apart. The bench reconfigures only between frames, after it has drained the queue. It generates the tick from a free-running divider, and it holds every serial bit for exactly sixteen ticks, so mid-bit sampling always falls well inside a bit.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
  localparam int ENTRY_W = 12;
  localparam int OVR_POS = 11;
  localparam int BRK_POS = 10;
  localparam int PER_POS = 9;
  localparam int FER_POS = 8;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP1, RX_STOP2, RX_BRK
  } rx_state_e;
endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/sio_rx_frame.sv
module sio_rx_frame
  import sio_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_s,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_par_stick,
  input  logic       cfg_two_stop,
  output logic       chr_valid,
  output logic [7:0] chr_data,
  output logic       chr_pe,
  output logic       chr_fe,
  output logic       chr_brk
);
  rx_state_e  state_q, state_d;
  logic [3:0] tcnt_q, tcnt_d;
  logic [2:0] bcnt_q, bcnt_d;
  logic [7:0] sh_q, sh_d;
  logic       par_q, par_d;
  logic       low_q, low_d;
  logic       fe_q, fe_d;
  logic       mid;
  logic [2:0] last_bit;
  logic       exp_par;

  assign mid      = tick && (tcnt_q == 4'd15);
  assign last_bit = 3'd4 + {1'b0, cfg_wlen};

  // right-align the character; bits above the word length shift in as zero
  assign chr_data = sh_q >> (2'd3 - cfg_wlen);

  always_comb begin
    if (cfg_par_stick)     exp_par = ~cfg_par_even;
    else if (cfg_par_even) exp_par = ^chr_data;
    else                   exp_par = ~(^chr_data);
  end

  assign chr_pe = cfg_par_en && !chr_brk && (par_q != exp_par);

  always_comb begin
    state_d   = state_q;
    tcnt_d    = tcnt_q;
    bcnt_d    = bcnt_q;
    sh_d      = sh_q;
    par_d     = par_q;
    low_d     = low_q;
    fe_d      = fe_q;
    chr_valid = 1'b0;
    chr_fe    = 1'b0;
    chr_brk   = 1'b0;
    unique case (state_q)
      RX_IDLE: if (tick && !rx_s) begin
        state_d = RX_START;
        tcnt_d  = 4'd0;
      end
      RX_START: if (tick) begin
        if (tcnt_q == 4'd7) begin
          if (rx_s) state_d = RX_IDLE;
          else begin
            state_d = RX_DATA;
            tcnt_d  = 4'd0;
            bcnt_d  = 3'd0;
            low_d   = 1'b1;
            fe_d    = 1'b0;
          end
        end else tcnt_d = tcnt_q + 4'd1;
      end
      RX_DATA: if (tick) begin
        tcnt_d = tcnt_q + 4'd1;
        if (mid) begin
          sh_d  = {rx_s, sh_q[7:1]};
          low_d = low_q & ~rx_s;
          if (bcnt_q == last_bit) state_d = cfg_par_en ? RX_PAR : RX_STOP1;
          else                    bcnt_d  = bcnt_q + 3'd1;
        end
      end
      RX_PAR: if (tick) begin
        tcnt_d = tcnt_q + 4'd1;
        if (mid) begin
          par_d   = rx_s;
          low_d   = low_q & ~rx_s;
          state_d = RX_STOP1;
        end
      end
      RX_STOP1: if (tick) begin
        tcnt_d = tcnt_q + 4'd1;
        if (mid) begin
          if (low_q && !rx_s) begin
            chr_valid = 1'b1;
            chr_brk   = 1'b1;
            state_d   = RX_BRK;
          end else if (!cfg_two_stop) begin
            chr_valid = 1'b1;
            chr_fe    = ~rx_s;
            state_d   = RX_IDLE;
          end else begin
            fe_d    = ~rx_s;
            state_d = RX_STOP2;
          end
        end
      end
      RX_STOP2: if (tick) begin
        tcnt_d = tcnt_q + 4'd1;
        if (mid) begin
          chr_valid = 1'b1;
          chr_fe    = fe_q | ~rx_s;
          state_d   = RX_IDLE;
        end
      end
      RX_BRK: if (tick && rx_s) state_d = RX_IDLE;
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      low_q   <= 1'b0;
      fe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      low_q   <= low_d;
      fe_q    <= fe_d;
    end
  end
endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 12,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deep_en,
  input  logic [2:0]    lvl,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop_req,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic          irq,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] thr;
  logic          pop;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (deep_en ? CW'(DEPTH) : CW'(1)));
  assign pop   = pop_req && !empty;
  assign rdata = mem[rptr_q];
  assign level = cnt_q;

  always_comb begin
    unique case (lvl)
      3'd0:    thr = CW'(DEPTH / 8);
      3'd1:    thr = CW'(DEPTH / 4);
      3'd2:    thr = CW'(DEPTH / 2);
      3'd3:    thr = CW'(DEPTH * 3 / 4);
      default: thr = CW'(DEPTH * 7 / 8);
    endcase
  end

  assign irq = deep_en ? (cnt_q >= thr) : !empty;

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= wptr_q + AW'(1);
      if (pop)  rptr_q <= rptr_q + AW'(1);
      if (push && !pop)      cnt_q <= cnt_q + CW'(1);
      else if (pop && !push) cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/sio_rx_unit.sv
module sio_rx_unit
  import sio_rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick16,
  input  logic               rxd,
  input  logic [1:0]         cfg_wlen,
  input  logic               cfg_par_en,
  input  logic               cfg_par_even,
  input  logic               cfg_par_stick,
  input  logic               cfg_two_stop,
  input  logic               cfg_fifo_en,
  input  logic [2:0]         cfg_lvl,
  input  logic               rd_en,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               rx_empty,
  output logic               rx_full,
  output logic               rx_irq
);
  logic [1:0]         rst_pipe_q;
  logic               rst_i_n;
  logic               rx_s;
  logic               chr_valid, chr_pe, chr_fe, chr_brk;
  logic [7:0]         chr_data;
  logic               ovr_q;
  logic               fifo_push;
  logic [ENTRY_W-1:0] fifo_wdata;
  logic [CW-1:0]      fifo_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  sio_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d(rxd), .q(rx_s)
  );

  sio_rx_frame u_frame (
    .clk(clk), .rst_n(rst_i_n), .tick(tick16), .rx_s(rx_s),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .cfg_two_stop(cfg_two_stop),
    .chr_valid(chr_valid), .chr_data(chr_data), .chr_pe(chr_pe),
    .chr_fe(chr_fe), .chr_brk(chr_brk)
  );

  assign fifo_push  = chr_valid && !rx_full;
  assign fifo_wdata = {ovr_q, chr_brk, chr_pe, chr_fe, chr_data};

  // a dropped character marks the next one that gets stored
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)                  ovr_q <= 1'b0;
    else if (chr_valid && rx_full) ovr_q <= 1'b1;
    else if (fifo_push)            ovr_q <= 1'b0;
  end

  sio_rx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_i_n), .deep_en(cfg_fifo_en), .lvl(cfg_lvl),
    .push(fifo_push), .wdata(fifo_wdata), .pop_req(rd_en),
    .rdata(rd_data), .empty(rx_empty), .full(rx_full), .irq(rx_irq),
    .level(fifo_level)
  );
endmodule

// File: rtl/sio_rx_checker.sv
module sio_rx_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          rd_en,
  input logic          chr_valid,
  input logic          fifo_push,
  input logic [11:0]   wdata,
  input logic [CW-1:0] level,
  input logic          rx_empty,
  input logic          rx_full,
  input logic          rx_irq
);
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  a_r9_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> level <= CW'(1));

  a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_empty && rx_full));

  a_r10_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> !rx_empty);

  a_r11_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rx_empty && !fifo_push |=> level == $past(level) - CW'(1));

  a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid && rx_full && !rd_en |=> level == $past(level));

  a_r7_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push && wdata[10] |-> (wdata[7:0] == 8'h00) && !wdata[9] && !wdata[8]);
endmodule

bind sio_rx_unit sio_rx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .fifo_en(cfg_fifo_en), .rd_en(rd_en),
  .chr_valid(chr_valid), .fifo_push(fifo_push), .wdata(fifo_wdata),
  .level(fifo_level), .rx_empty(rx_empty), .rx_full(rx_full), .rx_irq(rx_irq)
);

// File: tb/sio_rx_unit_bench.sv
module sio_rx_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick16 = 1'b0;
  logic        rxd = 1'b1;
  logic [1:0]  cfg_wlen = 2'd3;
  logic        cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_par_stick = 1'b0;
  logic        cfg_two_stop = 1'b0, cfg_fifo_en = 1'b1;
  logic [2:0]  cfg_lvl = 3'd2;
  logic        rd_en = 1'b0;
  logic [11:0] rd_data;
  logic        rx_empty, rx_full, rx_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int divc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    divc   <= (divc == TICK_DIV - 1) ? 0 : divc + 1;
    tick16 <= (divc == TICK_DIV - 1);
  end

  sio_rx_unit u_sio_rx_unit (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .cfg_two_stop(cfg_two_stop),
    .cfg_fifo_en(cfg_fifo_en), .cfg_lvl(cfg_lvl), .rd_en(rd_en),
    .rd_data(rd_data), .rx_empty(rx_empty), .rx_full(rx_full), .rx_irq(rx_irq)
  );

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %03h expected %03h", tag, got, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] wl, input logic pen, input logic pev,
                         input logic pst, input logic two, input logic fen,
                         input logic [2:0] lv);
    @(negedge clk);
    cfg_wlen = wl; cfg_par_en = pen; cfg_par_even = pev; cfg_par_stick = pst;
    cfg_two_stop = two; cfg_fifo_en = fen; cfg_lvl = lv;
  endtask

  task automatic line_bit(input logic b);
    rxd = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  function automatic logic odd_ones(input logic [7:0] d, input int nb);
    logic p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  task automatic send_frame(input logic [7:0] d, input int nb, input logic has_par,
                            input logic pbit, input int nstop,
                            input logic s1, input logic s2);
    @(negedge clk);
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(d[i]);
    if (has_par) line_bit(pbit);
    line_bit(s1);
    if (nstop == 2) line_bit(s2);
    line_bit(1'b1);
    line_bit(1'b1);
  endtask

  task automatic pop_expect(input logic [11:0] exp, input string tag);
    @(negedge clk);
    chk(tag, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12 empty after reset", {11'd0, rx_empty}, 12'd1);
    chk("R12 full after reset", {11'd0, rx_full}, 12'd0);
    chk("R12 irq after reset", {11'd0, rx_irq}, 12'd0);
  endtask

  task automatic t_wlen;
    for (int wl = 0; wl < 4; wl++) begin
      logic [7:0] mask;
      mask = 8'hFF >> (3 - wl);
      set_cfg(2'(wl), 0, 0, 0, 0, 1, 3'd2);
      send_frame(8'hD6, wl + 5, 0, 0, 1, 1, 1);
      pop_expect({4'h0, 8'hD6 & mask}, "R1 word length");
    end
  endtask

  task automatic t_parity;
    set_cfg(2'd2, 1, 1, 0, 0, 1, 3'd2);
    send_frame(8'h4B, 7, 1, odd_ones(8'h4B, 7), 1, 1, 1);
    pop_expect(12'h04B, "R2 even parity good");
    send_frame(8'h4B, 7, 1, ~odd_ones(8'h4B, 7), 1, 1, 1);
    pop_expect(12'h24B, "R2 even parity bad");
    set_cfg(2'd3, 1, 0, 0, 0, 1, 3'd2);
    send_frame(8'h81, 8, 1, ~odd_ones(8'h81, 8), 1, 1, 1);
    pop_expect(12'h081, "R2 odd parity good");
    send_frame(8'h81, 8, 1, odd_ones(8'h81, 8), 1, 1, 1);
    pop_expect(12'h281, "R2 odd parity bad");
  endtask

  task automatic t_stick;
    set_cfg(2'd3, 1, 1, 1, 0, 1, 3'd2);
    send_frame(8'h37, 8, 1, 1'b0, 1, 1, 1);
    pop_expect(12'h037, "R3 stick even-select expects 0");
    send_frame(8'h37, 8, 1, 1'b1, 1, 1, 1);
    pop_expect(12'h237, "R3 stick even-select rejects 1");
    set_cfg(2'd3, 1, 0, 1, 0, 1, 3'd2);
    send_frame(8'h36, 8, 1, 1'b1, 1, 1, 1);
    pop_expect(12'h036, "R3 stick odd-select expects 1");
  endtask

  task automatic t_nopar;
    set_cfg(2'd3, 0, 1, 0, 0, 1, 3'd2);
    send_frame(8'h07, 8, 0, 0, 1, 1, 1);
    pop_expect(12'h007, "R4 no parity bit consumed");
  endtask

  task automatic t_stop;
    set_cfg(2'd3, 0, 0, 0, 0, 1, 3'd2);
    send_frame(8'h5A, 8, 0, 0, 1, 0, 1);
    pop_expect(12'h15A, "R5 low stop framing error");
    set_cfg(2'd3, 0, 0, 0, 1, 1, 3'd2);
    send_frame(8'hA5, 8, 0, 0, 2, 1, 0);
    pop_expect(12'h1A5, "R5 low second stop");
    send_frame(8'hA5, 8, 0, 0, 2, 1, 1);
    pop_expect(12'h0A5, "R5 two good stops");
  endtask

  task automatic t_false_start;
    set_cfg(2'd3, 0, 0, 0, 0, 1, 3'd2);
    @(negedge clk);
    rxd = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk("R6 false start stores nothing", {11'd0, rx_empty}, 12'd1);
    send_frame(8'hC3, 8, 0, 0, 1, 1, 1);
    pop_expect(12'h0C3, "R6 recovers after false start");
  endtask

  task automatic t_break;
    set_cfg(2'd3, 0, 0, 0, 0, 1, 3'd2);
    @(negedge clk);
    rxd = 1'b0;
    repeat (40 * BIT_CLKS) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    pop_expect(12'h400, "R7 break entry");
    @(negedge clk);
    chk("R7 single break entry", {11'd0, rx_empty}, 12'd1);
  endtask

  task automatic t_depth_irq;
    set_cfg(2'd3, 0, 0, 0, 0, 1, 3'd2);
    for (int i = 0; i < 16; i++) begin
      send_frame(8'(8'h10 + i), 8, 0, 0, 1, 1, 1);
      if (i == 6) chk("R10 irq below 1/2", {11'd0, rx_irq}, 12'd0);
      if (i == 7) chk("R10 irq at 1/2", {11'd0, rx_irq}, 12'd1);
      if (i == 14) chk("R9 not full at 15", {11'd0, rx_full}, 12'd0);
    end
    chk("R9 full at 16", {11'd0, rx_full}, 12'd1);
    for (int i = 0; i < 16; i++) begin
      if (i == 2) begin
        cfg_lvl = 3'd4;
        @(negedge clk);
        chk("R10 irq at 7/8 with 14", {11'd0, rx_irq}, 12'd1);
      end
      if (i == 3) chk("R10 irq below 7/8 with 13", {11'd0, rx_irq}, 12'd0);
      pop_expect({4'h0, 8'(8'h10 + i)}, "R11 read order");
    end
    chk("R11 empty after drain", {11'd0, rx_empty}, 12'd1);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    chk("R11 read on empty keeps empty", {11'd0, rx_empty}, 12'd1);
    send_frame(8'h3C, 8, 0, 0, 1, 1, 1);
    pop_expect(12'h03C, "R11 read on empty harmless");
  endtask

  task automatic t_overrun;
    set_cfg(2'd3, 0, 0, 0, 0, 0, 3'd2);
    send_frame(8'h11, 8, 0, 0, 1, 1, 1);
    chk("R9 single slot full", {11'd0, rx_full}, 12'd1);
    chk("R10 irq when disabled and held", {11'd0, rx_irq}, 12'd1);
    send_frame(8'h22, 8, 0, 0, 1, 1, 1);
    pop_expect(12'h011, "R8 first kept");
    @(negedge clk);
    chk("R8 dropped char absent", {11'd0, rx_empty}, 12'd1);
    send_frame(8'h33, 8, 0, 0, 1, 1, 1);
    pop_expect(12'h833, "R8 overrun mark on next");
    send_frame(8'h44, 8, 0, 0, 1, 1, 1);
    pop_expect(12'h044, "R8 mark cleared");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_wlen();
    t_parity();
    t_stick();
    t_nopar();
    t_stop();
    t_false_start();
    t_break();
    t_depth_irq();
    t_overrun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule